// File: doc/BRIEF.md
# Commit-Gated Store Buffer

The block sits between an execution engine that issues memory writes speculatively and the memory write path. Each write (address, data, byte enables) enters a gated circular buffer and stays there, hidden from memory, until the controlling software settles its fate. A commit opens the gate for every entry held at that moment, and those entries then leave through a valid/ready write port, oldest first. A discard throws away every entry that has not yet been committed.

The buffer does not stall the engine silently when it fills. It reports how many entries it holds and whether it is full, so that the software can force a commit before it runs out of room. A store offered while the buffer is full is refused through its ready signal. Issuing commit and discard in the same cycle is a protocol violation. The block then lets the commit win and raises an error flag.

Top module: `gsb_top`

## Requirements
- R1: After reset, occupancy is 0, full is 0, st_ready is 1, mem_valid is 0 and proto_err is 0.
- R2: A buffered store never appears on the memory port before a commit. mem_valid stays 0 while no committed entry is waiting.
- R3: A commit makes every entry accepted before the commit cycle drainable, and mem_valid is 1 from the cycle after the commit.
- R4: Committed entries leave in acceptance order, one per cycle in which mem_valid and mem_ready are both 1. While mem_ready is 0, mem_addr, mem_data and mem_be hold their values.
- R5: A store accepted in the same cycle as a commit is not covered by that commit and stays gated.
- R6: A discard removes every uncommitted entry held before that cycle, and those entries never reach the memory port. A store accepted in the discard cycle is kept, gated.
- R7: A discard keeps committed entries that have not drained yet, and they continue to drain in order.
- R8: full is 1 exactly when occupancy equals the depth (16). In that state st_ready is 0 and an offered store is not taken.
- R9: When commit and discard are both 1 in one cycle, the commit takes effect, the discard is ignored, and proto_err is 1 in the following cycle only.
- R10: occupancy equals the number of stores accepted, minus the entries drained, minus the entries discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request from the execution engine |
| st_ready | output | 1 | Buffer can take a store this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| commit | input | 1 | Release all currently gated entries |
| discard | input | 1 | Drop all currently gated entries |
| mem_valid | output | 1 | A committed entry is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | 32 | Address of the oldest committed entry |
| mem_data | output | 32 | Data of the oldest committed entry |
| mem_be | output | 4 | Byte enables of the oldest committed entry |
| occupancy | output | 5 | Entries held, committed and gated together |
| full | output | 1 | Occupancy equals depth |
| proto_err | output | 1 | Commit and discard were both asserted in the previous cycle |

## Verification
A table of stores, commits, discards and idle cycles is applied with memory stalled. It shows whether the gate alone decides visibility and whether a discard shrinks occupancy by only the gated part. The drain after it tells apart a design that drops committed entries on discard from one that keeps them, and a discarded entry showing up at the port exposes a wrong discard. Directed cases put a store in the same cycle as a commit or a discard to fix the boundary on the correct side. They also fill the buffer to refuse a seventeenth store, and fire commit and discard together to see the commit win with a single error pulse.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  parameter int unsigned GSB_AW = 32;
  parameter int unsigned GSB_DW = 32;
  parameter int unsigned GSB_BW = GSB_DW / 8;

  typedef struct packed {
    logic [GSB_AW-1:0] addr;
    logic [GSB_DW-1:0] data;
    logic [GSB_BW-1:0] be;
  } gsb_entry_t;
endpackage

// File: rtl/gsb_store.sv
module gsb_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  gsb_pkg::gsb_entry_t wr_entry,
  input  logic [IW-1:0]       rd_idx,
  output gsb_pkg::gsb_entry_t rd_entry
);
  gsb_pkg::gsb_entry_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_entry;
  end

  assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/gsb_ctrl.sv
module gsb_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          commit,
  input  logic          discard,
  input  logic          mem_ready,
  output logic          st_ready,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          mem_valid,
  output logic [CW-1:0] occupancy,
  output logic          full,
  output logic          proto_err
);
  // Distance from lo up to hi on the wrapping pointer ring (DEPTH a power of two).
  function automatic logic [PW-1:0] span(input logic [PW-1:0] lo, input logic [PW-1:0] hi);
    return hi - lo;
  endfunction

  logic [PW-1:0] head_q, bound_q, tail_q;
  logic [PW-1:0] committed_cnt, gated_cnt, wr_ptr;
  logic          st_acc, drain_acc, commit_eff, discard_eff, err_q;

  assign committed_cnt = span(head_q, bound_q);
  assign gated_cnt     = span(bound_q, tail_q);
  assign occupancy     = CW'(span(head_q, tail_q));
  assign full          = (occupancy == CW'(DEPTH));
  assign st_ready      = !full;
  assign mem_valid     = (committed_cnt != '0);

  assign st_acc      = st_valid && st_ready;
  assign drain_acc   = mem_valid && mem_ready;
  assign commit_eff  = commit;
  assign discard_eff = discard && !commit;

  // On discard the new store overwrites the first dropped slot.
  assign wr_ptr = discard_eff ? bound_q : tail_q;
  assign wr_en  = st_acc;
  assign wr_idx = wr_ptr[IW-1:0];
  assign rd_idx = head_q[IW-1:0];
  assign proto_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      bound_q <= '0;
      tail_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      head_q  <= head_q + PW'(drain_acc);
      if (commit_eff) bound_q <= tail_q;
      tail_q  <= wr_ptr + PW'(st_acc);
      err_q   <= commit && discard;
    end
  end

  a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    span(head_q, tail_q) <= PW'(DEPTH));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |=> occupancy <= $past(occupancy));

  a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid && !commit |=> !mem_valid);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit && discard |=> proto_err && mem_valid);

  a_r6_discard_gated: assert property (@(posedge clk) disable iff (!rst_n)
    discard_eff |=> gated_cnt == PW'($past(st_acc)));

  a_r7_discard_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    discard_eff |=> committed_cnt == $past(committed_cnt) - PW'($past(drain_acc)));

  a_r5_commit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    commit_eff && st_acc |=> gated_cnt == PW'(1));
endmodule

// File: rtl/gsb_top.sv
module gsb_top #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         st_valid,
  output logic                         st_ready,
  input  logic [gsb_pkg::GSB_AW-1:0]   st_addr,
  input  logic [gsb_pkg::GSB_DW-1:0]   st_data,
  input  logic [gsb_pkg::GSB_BW-1:0]   st_be,
  input  logic                         commit,
  input  logic                         discard,
  output logic                         mem_valid,
  input  logic                         mem_ready,
  output logic [gsb_pkg::GSB_AW-1:0]   mem_addr,
  output logic [gsb_pkg::GSB_DW-1:0]   mem_data,
  output logic [gsb_pkg::GSB_BW-1:0]   mem_be,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy,
  output logic                         full,
  output logic                         proto_err
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic                wr_en;
  logic [IW-1:0]       wr_idx, rd_idx;
  gsb_pkg::gsb_entry_t wr_entry, rd_entry;

  assign wr_entry = '{addr: st_addr, data: st_data, be: st_be};
  assign mem_addr = rd_entry.addr;
  assign mem_data = rd_entry.data;
  assign mem_be   = rd_entry.be;

  gsb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .commit(commit),
    .discard(discard), .mem_ready(mem_ready), .st_ready(st_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .mem_valid(mem_valid),
    .occupancy(occupancy), .full(full), .proto_err(proto_err)
  );

  gsb_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .rd_idx(rd_idx), .rd_entry(rd_entry)
  );
endmodule

// File: tb/test_gsb_top.sv
module test_gsb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, commit = 1'b0, discard = 1'b0, mem_ready = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_ready, mem_valid, full, proto_err;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;
  logic [4:0]  occupancy;
  int n_checks = 0;
  int n_errors = 0;

  gsb_top i_gsb_top (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .commit(commit),
    .discard(discard), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .occupancy(occupancy), .full(full), .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  // op: 0 store, 1 commit, 2 discard, 3 idle
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [4:0]  exp_occ;
    logic        exp_mv;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{2'd0, 32'h0000_1000, 32'hAAAA_0001, 4'hF, 5'd1, 1'b0},
    '{2'd0, 32'h0000_1004, 32'hAAAA_0002, 4'h3, 5'd2, 1'b0},
    '{2'd1, 32'h0,         32'h0,         4'h0, 5'd2, 1'b1},
    '{2'd0, 32'h0000_1008, 32'hDEAD_0003, 4'h1, 5'd3, 1'b1},
    '{2'd2, 32'h0,         32'h0,         4'h0, 5'd2, 1'b1},
    '{2'd0, 32'h0000_100C, 32'hAAAA_0004, 4'hC, 5'd3, 1'b1},
    '{2'd3, 32'h0,         32'h0,         4'h0, 5'd3, 1'b1}
  };

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then return 1 ns after the edge.
  task automatic cyc(input logic sv, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] b, input logic c, input logic dis, input logic mr);
    st_valid = sv; st_addr = a; st_data = d; st_be = b;
    commit = c; discard = dis; mem_ready = mr;
    @(posedge clk); #1;
    st_valid = 0; commit = 0; discard = 0; mem_ready = 0;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    cyc(1, a, d, b, 0, 0, 0);
  endtask

  task automatic expect_head(input string req, input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] b);
    check(req, {mem_valid, mem_addr, mem_data, mem_be}, {1'b1, a, d, b});
  endtask

  task automatic drain();
    cyc(0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #4_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1", {occupancy, full, st_ready, mem_valid, proto_err}, {5'd0, 1'b0, 1'b1, 1'b0, 1'b0});

    // Table walk with memory stalled
    for (int i = 0; i < 7; i++) begin
      case (VEC[i].op)
        2'd0: cyc(1, VEC[i].addr, VEC[i].data, VEC[i].be, 0, 0, 0);
        2'd1: cyc(0, 0, 0, 0, 1, 0, 0);
        2'd2: cyc(0, 0, 0, 0, 0, 1, 0);
        default: cyc(0, 0, 0, 0, 0, 0, 0);
      endcase
      check("R10", {63'd0, occupancy}, {63'd0, VEC[i].exp_occ});
      check(VEC[i].exp_mv ? "R3" : "R2", {67'd0, mem_valid}, {67'd0, VEC[i].exp_mv});
    end
    // R4 head held across stall, R7 committed entries survive discard
    expect_head("R4", 32'h0000_1000, 32'hAAAA_0001, 4'hF);
    drain();
    expect_head("R7", 32'h0000_1004, 32'hAAAA_0002, 4'h3);
    drain();
    check("R2", {67'd0, mem_valid}, 68'd0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    expect_head("R6", 32'h0000_100C, 32'hAAAA_0004, 4'hC);
    drain();
    check("R10", {63'd0, occupancy}, 68'd0);

    // R5 store in commit cycle stays gated
    store(32'h2000, 32'hB001, 4'h1);
    cyc(1, 32'h2004, 32'hB002, 4'h2, 1, 0, 0);
    expect_head("R5", 32'h2000, 32'hB001, 4'h1);
    drain();
    check("R5", {63'd0, occupancy, mem_valid}, {63'd0, 5'd1, 1'b0});
    cyc(0, 0, 0, 0, 1, 0, 0);
    expect_head("R5", 32'h2004, 32'hB002, 4'h2);
    drain();

    // R6 store in discard cycle is kept
    store(32'h3000, 32'hD001, 4'hF);
    cyc(1, 32'h3004, 32'hD002, 4'h8, 0, 1, 0);
    check("R6", {63'd0, occupancy}, {63'd0, 5'd1});
    cyc(0, 0, 0, 0, 1, 0, 0);
    expect_head("R6", 32'h3004, 32'hD002, 4'h8);
    drain();

    // R8 fill to depth
    for (int k = 0; k < 16; k++) store(32'h4000 + 32'(k * 4), 32'hF000 + 32'(k), 4'hF);
    check("R8", {63'd0, occupancy, full}, {62'd0, 5'd16, 1'b1});
    check("R8", {67'd0, st_ready}, 68'd0);
    store(32'h5000, 32'h5555, 4'hF);
    check("R8", {63'd0, occupancy}, {63'd0, 5'd16});
    check("R2", {67'd0, mem_valid}, 68'd0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    check("R6", {63'd0, occupancy, full}, 68'd0);

    // R9 commit and discard together
    store(32'h6000, 32'hC001, 4'h5);
    cyc(0, 0, 0, 0, 1, 1, 0);
    check("R9", {65'd0, proto_err, mem_valid, full}, {65'd0, 1'b1, 1'b1, 1'b0});
    check("R9", {63'd0, occupancy}, {63'd0, 5'd1});
    cyc(0, 0, 0, 0, 0, 0, 0);
    check("R9", {67'd0, proto_err}, 68'd0);
    expect_head("R9", 32'h6000, 32'hC001, 4'h5);
    drain();
    check("R10", {63'd0, occupancy, mem_valid}, 68'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule